// File: doc/BRIEF.md
# Chirp Preamble Double-Peak Detector

This block finds the start of a packet whose preamble is a down-chirp followed at once by the conjugate up-chirp. It takes two magnitude streams that arrive together under one sample strobe. One stream comes from a correlator matched to the down-chirp and the other from a correlator matched to the up-chirp. A constant-false-alarm-rate gate runs on the down stream. Its threshold is the mean of a run of past reference cells, skipping a few guard cells next to the test cell, multiplied by a programmable scale. Once the gate fires, the detector follows the rising edge of the correlation to its top. That top is the down-chirp peak.

A carrier offset moves the two correlation peaks in opposite directions. The block therefore opens a window of programmable half-width around the nominal up-chirp position and takes the largest up-stream sample inside it. The pair of peaks must then pass a ratio test: the smaller peak must be at least a programmable fraction of the larger one. When the pair is accepted, the block reports the mean of the two peak positions as the packet timing. It also reports half the deviation of the measured spacing from the nominal spacing as a signed coarse frequency-offset figure. When the pair is rejected, the block goes back to hunting for a down-chirp and reports nothing.

Top module: `chirp_pair_detector`

## Requirements
- R1: After a synchronous reset, `det_valid` is 0, `det_time` is 0 and `det_cfo` is 0.
- R2: Strobes are numbered from 0 after reset. No down-stream sample with index below GUARD_CELLS+REF_CELLS (default 10) can start a candidate. As a result, a preamble placed entirely at the front produces no detection.
- R3: The down sample at index n starts a candidate only if dn·REF_CELLS·2^SCALE_FRAC > S·cfg_scale, a strict comparison. S is the sum of the down samples at indices n−GUARD_CELLS−1 down to n−GUARD_CELLS−REF_CELLS. cfg_scale is unsigned with SCALE_FRAC (default 4) fraction bits.
- R4: After a candidate starts, each following strictly larger down sample moves the peak. The first sample that is not larger fixes the down-chirp peak at the previous index.
- R5: Let k be the offset of an up sample from the down peak. Only up samples with SPACING−cfg_win ≤ k ≤ SPACING+cfg_win (default SPACING 32) are considered. The largest of them is taken, and on a tie the earliest one wins.
- R6: A pair is accepted only if min(dn_peak, up_peak)·2^RATIO_W ≥ cfg_ratio·max(dn_peak, up_peak). cfg_ratio is unsigned with RATIO_W (default 8) fraction bits.
- R7: An accepted pair raises `det_valid` for exactly one clock, in the cycle after the strobe at offset SPACING+cfg_win. With k the chosen up offset, `det_time` = peak index + floor(k/2), modulo 2^IDX_W, and `det_cfo` = floor((k−SPACING)/2) in two's complement.
- R8: A pair that fails the ratio test gives no pulse. The block then resumes hunting with the next strobe. Down samples that arrive while the window is open never start a new candidate.
- R9: Clock cycles with `in_valid` low advance nothing. They change neither the sample index nor the detection result, and `det_valid` is 0 in the cycle after such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe for both magnitude streams |
| dn_mag | input | MAG_W | Down-chirp correlation magnitude |
| up_mag | input | MAG_W | Up-chirp correlation magnitude |
| cfg_scale | input | SCALE_W | Threshold scale over the noise mean, SCALE_FRAC fraction bits |
| cfg_ratio | input | RATIO_W | Minimum smaller-to-larger peak ratio, RATIO_W fraction bits |
| cfg_win | input | WIN_W | Search half-width in samples |
| det_valid | output | 1 | One-cycle pulse for an accepted preamble |
| det_time | output | IDX_W | Timing index, the mean of the two peak positions |
| det_cfo | output | OFF_W | Signed coarse frequency-offset estimate in samples |

## Verification
The case to watch is an up-chirp peak that lands on the last offset of the search window. In that strobe the window tracker must fold the new maximum into its result while the controller closes the window, runs the ratio test and produces the outputs. A stale maximum would either drop the pair or report the wrong offset. Directed packets place the peak exactly at +cfg_win and at −cfg_win−1 and +cfg_win+1, and the random packets sweep the window half-width. The reported offset and timing are compared with bench functions that evaluate the threshold, climb, window and ratio rules on every strobe.

// File: rtl/chirp_pd_pkg.sv
package chirp_pd_pkg;

  // Controller phases of the pair detector.
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,  // waiting for the noise gate on the down stream
    ST_CLIMB  = 2'd1,  // following the rising down correlation
    ST_SEARCH = 2'd2   // window around the nominal up-chirp position
  } pd_state_e;

endpackage

// File: rtl/cpd_cfar_gate.sv
module cpd_cfar_gate #(
  parameter int MAG_W       = 12,
  parameter int REF_CELLS   = 8,
  parameter int GUARD_CELLS = 2,
  parameter int SCALE_W     = 8,
  parameter int SCALE_FRAC  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strobe,
  input  logic [MAG_W-1:0]   cut,
  input  logic [SCALE_W-1:0] scale,
  output logic               armed,
  output logic               hit
);

  localparam int DEPTH = GUARD_CELLS + REF_CELLS;
  localparam int SUM_W = MAG_W + $clog2(REF_CELLS + 1);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int CMP_W = SUM_W + SCALE_W + SCALE_FRAC;

  logic [MAG_W-1:0] taps [DEPTH];
  logic [MAG_W-1:0] enter_v;
  logic [MAG_W-1:0] leave_v;
  logic [SUM_W-1:0] ref_sum;
  logic [CNT_W-1:0] fill;
  logic [CMP_W-1:0] cut_scaled;
  logic [CMP_W-1:0] noise_scaled;

  // The sample that crosses from the guard zone into the reference zone.
  generate
    if (GUARD_CELLS == 0) begin : g_no_guard
      assign enter_v = cut;
    end else begin : g_guard
      assign enter_v = taps[GUARD_CELLS-1];
    end
  endgenerate

  assign leave_v = taps[DEPTH-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) taps[k] <= '0;
      ref_sum <= '0;
      fill    <= '0;
    end else if (strobe) begin
      taps[0] <= cut;
      for (int k = 1; k < DEPTH; k++) taps[k] <= taps[k-1];
      ref_sum <= ref_sum + SUM_W'(enter_v) - SUM_W'(leave_v);
      if (fill != CNT_W'(DEPTH)) fill <= fill + 1'b1;
    end
  end

  assign armed        = (fill == CNT_W'(DEPTH));
  assign cut_scaled   = (CMP_W'(cut) * CMP_W'(REF_CELLS)) << SCALE_FRAC;
  assign noise_scaled = CMP_W'(ref_sum) * CMP_W'(scale);
  assign hit          = armed && (cut_scaled > noise_scaled);

endmodule

// File: rtl/cpd_window_max.sv
module cpd_window_max #(
  parameter int MAG_W = 12,
  parameter int OFF_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             sample_en,
  input  logic             in_win,
  input  logic [MAG_W-1:0] mag,
  input  logic [OFF_W-1:0] off,
  output logic             best_any,
  output logic [MAG_W-1:0] best_mag,
  output logic [OFF_W-1:0] best_off
);

  logic             held_any;
  logic [MAG_W-1:0] held_mag;
  logic [OFF_W-1:0] held_off;
  logic             take;

  // Strictly greater keeps the earliest sample on a tie.
  assign take = sample_en && in_win && (!held_any || (mag > held_mag));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      held_any <= 1'b0;
      held_mag <= '0;
      held_off <= '0;
    end else if (take) begin
      held_any <= 1'b1;
      held_mag <= mag;
      held_off <= off;
    end
  end

  // The current sample is merged in so a decision in the last slot sees it.
  assign best_any = held_any || take;
  assign best_mag = take ? mag : held_mag;
  assign best_off = take ? off : held_off;

endmodule

// File: rtl/cpd_ratio_check.sv
module cpd_ratio_check #(
  parameter int MAG_W   = 12,
  parameter int RATIO_W = 8
) (
  input  logic [MAG_W-1:0]   peak_a,
  input  logic [MAG_W-1:0]   peak_b,
  input  logic [RATIO_W-1:0] ratio,
  output logic               pass
);

  localparam int P_W = MAG_W + RATIO_W;

  logic [MAG_W-1:0] lo_pk;
  logic [MAG_W-1:0] hi_pk;
  logic [P_W-1:0]   lo_scaled;
  logic [P_W-1:0]   hi_scaled;

  assign lo_pk     = (peak_a < peak_b) ? peak_a : peak_b;
  assign hi_pk     = (peak_a < peak_b) ? peak_b : peak_a;
  assign lo_scaled = {lo_pk, {RATIO_W{1'b0}}};
  assign hi_scaled = P_W'(ratio) * P_W'(hi_pk);
  assign pass      = (lo_scaled >= hi_scaled);

endmodule

// File: rtl/chirp_pair_detector.sv
module chirp_pair_detector
  import chirp_pd_pkg::*;
#(
  parameter int MAG_W       = 12,
  parameter int REF_CELLS   = 8,
  parameter int GUARD_CELLS = 2,
  parameter int SCALE_W     = 8,
  parameter int SCALE_FRAC  = 4,
  parameter int RATIO_W     = 8,
  parameter int WIN_W       = 4,
  parameter int SPACING     = 32,
  parameter int IDX_W       = 16,
  parameter int OFF_W       = $clog2(SPACING + (1 << WIN_W) + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [MAG_W-1:0]        dn_mag,
  input  logic [MAG_W-1:0]        up_mag,
  input  logic [SCALE_W-1:0]      cfg_scale,
  input  logic [RATIO_W-1:0]      cfg_ratio,
  input  logic [WIN_W-1:0]        cfg_win,
  output logic                    det_valid,
  output logic [IDX_W-1:0]        det_time,
  output logic signed [OFF_W-1:0] det_cfo
);

  // SPACING must exceed 2**WIN_W + 1 so the window never starts before offset 2.

  pd_state_e        state;
  logic [IDX_W-1:0] sample_idx;
  logic [MAG_W-1:0] pk_mag;
  logic [IDX_W-1:0] pk_pos;
  logic [OFF_W-1:0] rel_off;

  logic             cfar_armed;
  logic             cfar_hit;
  logic             in_search;
  logic [OFF_W-1:0] win_lo;
  logic [OFF_W-1:0] win_hi;
  logic             in_win;
  logic             at_end;
  logic             best_any;
  logic [MAG_W-1:0] best_mag;
  logic [OFF_W-1:0] best_off;
  logic             ratio_ok;
  logic             accept;
  logic signed [OFF_W-1:0] spacing_dev;

  cpd_cfar_gate #(
    .MAG_W       (MAG_W),
    .REF_CELLS   (REF_CELLS),
    .GUARD_CELLS (GUARD_CELLS),
    .SCALE_W     (SCALE_W),
    .SCALE_FRAC  (SCALE_FRAC)
  ) u_cfar (
    .clk    (clk),
    .rst    (rst),
    .strobe (in_valid),
    .cut    (dn_mag),
    .scale  (cfg_scale),
    .armed  (cfar_armed),
    .hit    (cfar_hit)
  );

  assign in_search = (state == ST_SEARCH);
  assign win_lo    = OFF_W'(SPACING) - OFF_W'(cfg_win);
  assign win_hi    = OFF_W'(SPACING) + OFF_W'(cfg_win);
  assign in_win    = in_search && (rel_off >= win_lo) && (rel_off <= win_hi);
  assign at_end    = in_search && (rel_off == win_hi);

  cpd_window_max #(
    .MAG_W (MAG_W),
    .OFF_W (OFF_W)
  ) u_wmax (
    .clk       (clk),
    .rst       (rst),
    .clear     (!in_search),
    .sample_en (in_valid),
    .in_win    (in_win),
    .mag       (up_mag),
    .off       (rel_off),
    .best_any  (best_any),
    .best_mag  (best_mag),
    .best_off  (best_off)
  );

  cpd_ratio_check #(
    .MAG_W   (MAG_W),
    .RATIO_W (RATIO_W)
  ) u_ratio (
    .peak_a (pk_mag),
    .peak_b (best_mag),
    .ratio  (cfg_ratio),
    .pass   (ratio_ok)
  );

  assign accept      = in_valid && at_end && best_any && ratio_ok;
  assign spacing_dev = $signed(best_off - OFF_W'(SPACING));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_HUNT;
      sample_idx <= '0;
      pk_mag     <= '0;
      pk_pos     <= '0;
      rel_off    <= '0;
      det_valid  <= 1'b0;
      det_time   <= '0;
      det_cfo    <= '0;
    end else begin
      det_valid <= 1'b0;
      if (in_valid) begin
        sample_idx <= sample_idx + 1'b1;
        unique case (state)
          ST_HUNT: begin
            if (cfar_hit) begin
              state  <= ST_CLIMB;
              pk_mag <= dn_mag;
              pk_pos <= sample_idx;
            end
          end
          ST_CLIMB: begin
            if (dn_mag > pk_mag) begin
              pk_mag <= dn_mag;
              pk_pos <= sample_idx;
            end else begin
              // This sample sits at offset 1; the next one is at offset 2.
              state   <= ST_SEARCH;
              rel_off <= OFF_W'(2);
            end
          end
          ST_SEARCH: begin
            rel_off <= rel_off + 1'b1;
            if (at_end) begin
              state <= ST_HUNT;
              if (accept) begin
                det_valid <= 1'b1;
                det_time  <= pk_pos + IDX_W'(best_off >> 1);
                det_cfo   <= spacing_dev >>> 1;
              end
            end
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

endmodule

// File: rtl/chirp_pair_detector_chk.sv
module chirp_pair_detector_chk #(
  parameter int OFF_W = 7,
  parameter int WIN_W = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    det_valid,
  input logic signed [OFF_W-1:0] det_cfo,
  input logic [WIN_W-1:0]        cfg_win,
  input logic                    cfar_armed,
  input logic                    in_search,
  input logic [OFF_W-1:0]        rel_off,
  input logic [OFF_W-1:0]        win_hi
);

  logic signed [OFF_W+1:0] cfo_twice;
  logic signed [OFF_W+1:0] win_s;

  assign cfo_twice = {det_cfo[OFF_W-1], det_cfo, 1'b0};
  assign win_s     = $signed({{(OFF_W+2-WIN_W){1'b0}}, cfg_win});

  // R7: an accepted pair is reported for a single cycle only.
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    det_valid |=> !det_valid);

  // R2: no report can exist before the reference cells have filled.
  assert_armed_first_R2: assert property (@(posedge clk) disable iff (rst)
    det_valid |-> cfar_armed);

  // R9: a cycle without a strobe cannot produce a report.
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !det_valid);

  // R5: the window counter never runs past the last window slot.
  assert_window_bound_R5: assert property (@(posedge clk) disable iff (rst)
    in_search |-> (rel_off <= win_hi));

  // R5: the reported offset lies inside the half-width window.
  assert_cfo_span_R5: assert property (@(posedge clk) disable iff (rst)
    det_valid |-> ((cfo_twice <= win_s) && (cfo_twice >= -win_s - 1)));

endmodule

bind chirp_pair_detector chirp_pair_detector_chk #(
  .OFF_W (OFF_W),
  .WIN_W (WIN_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .det_valid  (det_valid),
  .det_cfo    (det_cfo),
  .cfg_win    (cfg_win),
  .cfar_armed (cfar_armed),
  .in_search  (in_search),
  .rel_off    (rel_off),
  .win_hi     (win_hi)
);

// File: tb/chirp_pair_detector_bench.sv
`timescale 1ns/1ps
module chirp_pair_detector_bench;

  localparam int MAG_W = 12;
  localparam int WIN_W = 4;
  localparam int IDX_W = 16;
  localparam int SP    = 32;
  localparam int OFF_W = $clog2(SP + (1 << WIN_W) + 1) + 1;
  localparam int NONE  = 999;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [MAG_W-1:0] dn_mag = '0;
  logic [MAG_W-1:0] up_mag = '0;
  logic [7:0] cfg_scale = 8'd64;
  logic [7:0] cfg_ratio = 8'd128;
  logic [WIN_W-1:0] cfg_win = 4'd5;
  logic det_valid;
  logic [IDX_W-1:0] det_time;
  logic signed [OFF_W-1:0] det_cfo;

  always #2.5 clk = ~clk;

  chirp_pair_detector u_chirp_pair_detector (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .dn_mag    (dn_mag),
    .up_mag    (up_mag),
    .cfg_scale (cfg_scale),
    .cfg_ratio (cfg_ratio),
    .cfg_win   (cfg_win),
    .det_valid (det_valid),
    .det_time  (det_time),
    .det_cfo   (det_cfo)
  );

  int n_checks = 0;
  int n_fail = 0;
  string cur_tag = "R1";
  bit done = 1'b0;

  int m_hist [16384];
  int m_n = 0;
  int m_state = 0;
  int m_pk = 0;
  int m_pos = 0;
  int m_best = 0;
  int m_boff = 0;
  bit m_have = 1'b0;

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int nz(input bit flat);
    return flat ? 8 : int'($urandom % 16);
  endfunction

  // Expected behaviour per strobe, written from the requirements.
  task automatic model_step(input int dn, input int up, output bit pulse,
                            output int t, output int cfo);
    int n; int sum; int off; int lo; int hi; int w;
    pulse = 1'b0; t = 0; cfo = 0;
    n = m_n;
    if (n < 16384) m_hist[n] = dn;
    m_n++;
    w = int'(cfg_win);
    case (m_state)
      0: begin
        if (n >= 10) begin
          sum = 0;
          for (int k = 0; k < 8; k++) sum += m_hist[n-3-k];
          if (dn * 8 * 16 > sum * int'(cfg_scale)) begin
            m_state = 1; m_pk = dn; m_pos = n;
          end
        end
      end
      1: begin
        if (dn > m_pk) begin
          m_pk = dn; m_pos = n;
        end else begin
          m_state = 2; m_have = 1'b0;
        end
      end
      default: begin
        off = n - m_pos;
        if (off >= SP - w && off <= SP + w && (!m_have || up > m_best)) begin
          m_best = up; m_boff = off; m_have = 1'b1;
        end
        if (off == SP + w) begin
          m_state = 0;
          lo = (m_pk < m_best) ? m_pk : m_best;
          hi = (m_pk < m_best) ? m_best : m_pk;
          if (lo * 256 >= int'(cfg_ratio) * hi) begin
            pulse = 1'b1;
            t = (m_pos + m_boff / 2) & 16'hFFFF;
            cfo = (m_boff - SP) >>> 1;
          end
        end
      end
    endcase
  endtask

  task automatic step(input int dn, input int up, input bit v, output bit seen,
                      output int t_obs, output int cfo_obs);
    bit ep; int et; int ec;
    @(negedge clk);
    if (dn > 4095) dn = 4095;
    if (up > 4095) up = 4095;
    in_valid = v;
    dn_mag = MAG_W'(dn);
    up_mag = MAG_W'(up);
    ep = 1'b0; et = 0; ec = 0;
    if (v) model_step(dn, up, ep, et, ec);
    @(posedge clk);
    #1;
    seen = det_valid;
    t_obs = int'(det_time);
    cfo_obs = int'(det_cfo);
    chk_eq({cur_tag, " det_valid"}, int'(det_valid), int'(ep));
    if (ep && det_valid) begin
      chk_eq({cur_tag, " R7 det_time"}, t_obs, et);
      chk_eq({cur_tag, " R7 det_cfo"}, cfo_obs, ec);
    end
  endtask

  task automatic pstep(input int dn, input int up, input int gap_pct,
                       inout int ndet, inout int cfo_o, inout int time_o);
    bit s; int t; int c;
    if (gap_pct > 0 && int'($urandom % 100) < gap_pct) begin
      step(0, 0, 1'b0, s, t, c);
      if ($urandom % 2 == 0) step(0, 0, 1'b0, s, t, c);
    end
    step(dn, up, 1'b1, s, t, c);
    if (s) begin
      ndet++; cfo_o = c; time_o = t;
    end
  endtask

  task automatic settle();
    bit s; int t; int c;
    while (m_state != 0) step(nz(1'b0), nz(1'b0), 1'b1, s, t, c);
    step(0, 0, 1'b0, s, t, c);
  endtask

  task automatic send_pkt(input int dn_pk, input int d1, input int up1,
                          input int d2, input int up2, input int spike_off,
                          input bit flat, input bit ramp, input int gap_pct,
                          output int ndet, output int cfo_o, output int time_o,
                          output int pk_idx);
    int last; int dn; int up;
    ndet = 0; cfo_o = 0; time_o = 0;
    for (int i = 0; i < 12; i++) pstep(nz(flat), nz(flat), gap_pct, ndet, cfo_o, time_o);
    pstep(ramp ? dn_pk / 4 : nz(flat), nz(flat), gap_pct, ndet, cfo_o, time_o);
    pstep(ramp ? dn_pk / 2 : nz(flat), nz(flat), gap_pct, ndet, cfo_o, time_o);
    pk_idx = m_n;
    pstep(dn_pk, nz(flat), gap_pct, ndet, cfo_o, time_o);
    last = SP + int'(cfg_win) + 3;
    for (int k = 1; k <= last; k++) begin
      dn = (k == spike_off) ? 4000 : ((k == 1) ? dn_pk / 3 : nz(flat));
      up = (k == SP + d1) ? up1 : ((k == SP + d2) ? up2 : nz(flat));
      pstep(dn, up, gap_pct, ndet, cfo_o, time_o);
    end
    settle();
  endtask

  initial begin
    bit s; int t; int c; int nd; int cf; int tm; int pk; int tot;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    cur_tag = "R1";
    chk_eq("R1 det_valid after reset", int'(det_valid), 0);
    chk_eq("R1 det_time after reset", int'(det_time), 0);
    chk_eq("R1 det_cfo after reset", int'(det_cfo), 0);

    // R2: a full preamble before the reference cells are filled.
    cur_tag = "R2";
    tot = 0;
    step(250, 5, 1'b1, s, t, c); tot += int'(s);
    step(500, 5, 1'b1, s, t, c); tot += int'(s);
    step(1000, 5, 1'b1, s, t, c); tot += int'(s);
    for (int k = 1; k <= 45; k++) begin
      step(nz(1'b0), (k == SP) ? 1000 : nz(1'b0), 1'b1, s, t, c);
      tot += int'(s);
    end
    settle();
    chk_eq("R2 detections before arming", tot, 0);

    // R3: flat noise 8 gives threshold 32 at scale 4.0; the compare is strict.
    cur_tag = "R3";
    send_pkt(32, 0, 600, NONE, 0, -1, 1'b1, 1'b0, 0, nd, cf, tm, pk);
    chk_eq("R3 sample equal to threshold", nd, 0);
    send_pkt(33, 0, 33, NONE, 0, -1, 1'b1, 1'b0, 0, nd, cf, tm, pk);
    chk_eq("R3 sample above threshold", nd, 1);
    chk_eq("R3 cfo of centred pair", cf, 0);
    chk_eq("R3 timing of centred pair", tm, (pk + 16) & 16'hFFFF);

    // R4: the ramp crosses early, and the top of the ramp is the peak.
    cur_tag = "R4";
    send_pkt(1000, 2, 900, NONE, 0, -1, 1'b0, 1'b1, 0, nd, cf, tm, pk);
    chk_eq("R4 detection", nd, 1);
    chk_eq("R4 timing from ramp top", tm, (pk + 17) & 16'hFFFF);

    // R7: sign and rounding of the offset estimate.
    cur_tag = "R7";
    send_pkt(1000, 3, 900, NONE, 0, -1, 1'b0, 1'b1, 0, nd, cf, tm, pk);
    chk_eq("R7 cfo for +3", cf, 1);
    send_pkt(1000, -4, 900, NONE, 0, -1, 1'b0, 1'b1, 0, nd, cf, tm, pk);
    chk_eq("R7 cfo for -4", cf, -2);
    send_pkt(1000, -3, 900, NONE, 0, -1, 1'b0, 1'b1, 0, nd, cf, tm, pk);
    chk_eq("R7 cfo for -3", cf, -2);
    chk_eq("R7 timing for -3", tm, (pk + 14) & 16'hFFFF);

    // R5: peak on the last window slot, and an equal pair of peaks.
    cur_tag = "R5";
    send_pkt(1000, 5, 900, NONE, 0, -1, 1'b0, 1'b1, 0, nd, cf, tm, pk);
    chk_eq("R5 peak on last slot detected", nd, 1);
    chk_eq("R5 peak on last slot cfo", cf, 2);
    send_pkt(1000, -5, 900, NONE, 0, -1, 1'b0, 1'b1, 0, nd, cf, tm, pk);
    chk_eq("R5 peak on first slot cfo", cf, -3);
    send_pkt(1000, -1, 800, 2, 800, -1, 1'b0, 1'b1, 0, nd, cf, tm, pk);
    chk_eq("R5 tie keeps earliest", cf, -1);
    chk_eq("R5 tie timing", tm, (pk + 15) & 16'hFFFF);

    // R8: out-of-window peaks, and down samples during the window.
    cur_tag = "R8";
    send_pkt(1000, 6, 900, NONE, 0, -1, 1'b0, 1'b1, 0, nd, cf, tm, pk);
    chk_eq("R8 peak after window rejected", nd, 0);
    send_pkt(1000, -6, 900, NONE, 0, -1, 1'b0, 1'b1, 0, nd, cf, tm, pk);
    chk_eq("R8 peak before window rejected", nd, 0);
    send_pkt(1000, 0, 900, NONE, 0, 10, 1'b0, 1'b1, 0, nd, cf, tm, pk);
    chk_eq("R8 spike in window ignored", nd, 1);
    chk_eq("R8 spike does not move timing", tm, (pk + 16) & 16'hFFFF);

    // R6: ratio boundary at one half, in both directions.
    cur_tag = "R6";
    send_pkt(1000, 0, 500, NONE, 0, -1, 1'b0, 1'b1, 0, nd, cf, tm, pk);
    chk_eq("R6 up at half accepted", nd, 1);
    send_pkt(1000, 0, 499, NONE, 0, -1, 1'b0, 1'b1, 0, nd, cf, tm, pk);
    chk_eq("R6 up below half rejected", nd, 0);
    send_pkt(1000, 0, 2000, NONE, 0, -1, 1'b0, 1'b1, 0, nd, cf, tm, pk);
    chk_eq("R6 down at half accepted", nd, 1);
    send_pkt(1000, 0, 2001, NONE, 0, -1, 1'b0, 1'b1, 0, nd, cf, tm, pk);
    chk_eq("R6 down below half rejected", nd, 0);

    // R9: idle cycles scattered through a packet.
    cur_tag = "R9";
    send_pkt(1000, 1, 900, NONE, 0, -1, 1'b0, 1'b1, 40, nd, cf, tm, pk);
    chk_eq("R9 detection with gaps", nd, 1);
    chk_eq("R9 cfo with gaps", cf, 0);
    chk_eq("R9 timing with gaps", tm, (pk + 16) & 16'hFFFF);

    // Random packets, checked strobe by strobe against the model.
    cur_tag = "R7 random";
    for (int p = 0; p < 40; p++) begin
      int dpk; int d1; int d2; int u1; int u2; int sp;
      cfg_win   = WIN_W'(3 + $urandom % 8);
      cfg_ratio = 8'(64 + $urandom % 137);
      cfg_scale = 8'(64 + $urandom % 49);
      dpk = 200 + int'($urandom % 3800);
      d1  = int'($urandom % 21) - 10;
      u1  = dpk * (30 + int'($urandom % 130)) / 100;
      d2  = ($urandom % 4 == 0) ? int'($urandom % 21) - 10 : NONE;
      u2  = dpk * (30 + int'($urandom % 130)) / 100;
      sp  = ($urandom % 5 == 0) ? 2 + int'($urandom % 30) : -1;
      send_pkt(dpk, d1, u1, d2, u2, sp, 1'b0, 1'b1, 15, nd, cf, tm, pk);
      step(0, 0, 1'b0, s, t, c);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule